// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one direct memory access channel. It copies one datum at a time from a source address to a destination address. Both addresses are 20 bits wide and index one flat 1 MB space. Each end of the copy can be in memory space or in I/O space. Each copy is a fetch cycle followed by a deposit cycle on a simple valid/ready bus. The fetched value is held in an internal register between the two cycles. After the deposit completes, each pointer steps up, steps down or holds, according to its own mode. The step size follows the transfer width.

Software configures the channel through plain input pins. A transfer starts when any of three request inputs is high while the channel is armed. The three inputs are an external pin, an internal line and a software bit. The engine runs one transfer per accepted request. It starts another transfer straight away if a request is still high when it returns to idle. A parameter sets the data bus to 8 or 16 bits. On the 16-bit bus, an odd-aligned word is split into byte cycles. On the 8-bit bus, word mode is rejected.

Top module: `dma_xfer_chan`

## Requirements
- R1: The bus space bit `bus_io` (1 = I/O space) equals `cfg_src_io` during fetch cycles and `cfg_dst_io` during deposit cycles. This supports all four pairings: memory to I/O, I/O to memory, memory to memory and I/O to I/O.
- R2: Every bus address carries all 20 pointer bits, in both spaces. I/O cycles at or above 0x10000 are issued without truncation.
- R3: Each pointer has a 2-bit mode: 00 hold, 01 increment, 10 decrement, 11 hold. The update happens only in the clock edge that completes the last deposit, and it wraps modulo 2^20.
- R4: The pointer step is 2 when `cfg_word` = 1 and 1 when `cfg_word` = 0.
- R5: A transfer issues its fetch (`bus_write` = 0) before its deposit (`bus_write` = 1). On the 16-bit bus, a byte at an odd address uses data bits 15:8 and a byte at an even address uses bits 7:0. A deposited byte is driven on both lanes.
- R6: With `BUS_W` = 16, a word transfer where either pointer is odd runs four byte cycles back to back: fetch S, fetch S+1, deposit D, deposit D+1. The byte from S goes to D.
- R7: With `BUS_W` = 16, a word transfer with both pointers even runs one 16-bit fetch and one 16-bit deposit (`bus_word` = 1). A 16-bit cycle never carries an odd address.
- R8: With `BUS_W` = 8, `cfg_word` = 1 raises `cfg_err`, and no bus cycle starts while the error is present.
- R9: Any one of `ext_req`, `int_req` or `sw_req` starts a transfer when `cfg_arm` = 1. While `cfg_arm` = 0, all three are ignored.
- R10: While `bus_valid` = 1 and `bus_ready` = 0, the engine holds valid, address, space, size, direction and write data unchanged into the next cycle.
- R11: `xfer_done` pulses for exactly one cycle after the completing deposit, and the updated pointers are visible in that same cycle.
- R12: After reset, `bus_valid`, `busy`, `xfer_done` and both pointers are 0.
- R13: `ptr_load` loads both pointers only while the engine is idle. During a transfer it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_arm | input | 1 | Channel armed; requests count only while it is high |
| cfg_word | input | 1 | 1 = word transfers, 0 = byte transfers |
| cfg_src_io | input | 1 | Source is in I/O space |
| cfg_dst_io | input | 1 | Destination is in I/O space |
| cfg_src_mode | input | 2 | Source pointer step mode |
| cfg_dst_mode | input | 2 | Destination pointer step mode |
| ptr_load | input | 1 | Load both pointers (idle only) |
| ptr_src_in | input | ADDR_W | Source pointer load value |
| ptr_dst_in | input | ADDR_W | Destination pointer load value |
| ext_req | input | 1 | External request pin |
| int_req | input | 1 | Internal request line |
| sw_req | input | 1 | Software request bit |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Bus cycle acknowledged |
| bus_write | output | 1 | 1 = deposit, 0 = fetch |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_word | output | 1 | 1 = full-width 16-bit cycle |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | BUS_W | Deposit data |
| bus_rdata | input | BUS_W | Fetch data |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | Illegal word mode on an 8-bit bus |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the split word, where the fetched byte lanes alternate between the upper and lower halves of the bus across consecutive cycles. The stimulus loads an odd source pointer with word mode set. The bus model returns a recognisable byte on the addressed lane and a filler value on the other lane, so a wrong lane choice shows up in the deposited data. A second hard case is a pointer load that arrives during a stalled transfer. The bus model inserts wait states so that the load lands while the engine is busy. A separate 8-bit instance covers the illegal word mode.

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan #(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_arm,
  input  logic              cfg_word,
  input  logic              cfg_src_io,
  input  logic              cfg_dst_io,
  input  logic [1:0]        cfg_src_mode,
  input  logic [1:0]        cfg_dst_mode,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_src_in,
  input  logic [ADDR_W-1:0] ptr_dst_in,
  input  logic              ext_req,
  input  logic              int_req,
  input  logic              sw_req,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic              bus_io,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              busy,
  output logic              cfg_err,
  output logic              xfer_done
);
  localparam bit WIDE  = (BUS_W == 16);
  localparam int LANES = BUS_W / 8;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_WR0, S_WR1} state_t;
  state_t state;

  logic       l_word, l_split, l_src_io, l_dst_io;
  logic [1:0] l_src_mode, l_dst_mode;
  logic [15:0] hold;

  logic any_req, start, finish, is_wr;
  logic [7:0] rd_byte, wr_byte;

  assign cfg_err = !WIDE && cfg_word;
  assign any_req = cfg_arm && (ext_req || int_req || sw_req) && !cfg_err;
  assign start   = (state == S_IDLE) && any_req && !ptr_load;
  assign is_wr   = (state == S_WR0) || (state == S_WR1);
  assign finish  = bus_ready && (((state == S_WR0) && !l_split) || (state == S_WR1));

  assign busy      = (state != S_IDLE);
  assign bus_valid = busy;
  assign bus_write = is_wr;
  assign bus_io    = is_wr ? l_dst_io : l_src_io;
  assign bus_word  = l_word && !l_split;
  assign bus_addr  = (state == S_RD1) ? src_ptr + ADDR_W'(1) :
                     (state == S_WR1) ? dst_ptr + ADDR_W'(1) :
                     is_wr            ? dst_ptr : src_ptr;

  assign rd_byte   = (WIDE && bus_addr[0]) ? bus_rdata[BUS_W-1 -: 8] : bus_rdata[7:0];
  assign wr_byte   = (state == S_WR1) ? hold[15:8] : hold[7:0];
  assign bus_wdata = bus_word ? hold[BUS_W-1:0] : {LANES{wr_byte}};

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                 input logic [1:0] m, input logic w);
    logic [ADDR_W-1:0] d;
    d = w ? ADDR_W'(2) : ADDR_W'(1);
    case (m)
      2'b01:   return p + d;
      2'b10:   return p - d;
      default: return p;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      l_word     <= 1'b0;
      l_split    <= 1'b0;
      l_src_io   <= 1'b0;
      l_dst_io   <= 1'b0;
      l_src_mode <= 2'b00;
      l_dst_mode <= 2'b00;
      hold       <= '0;
      src_ptr    <= '0;
      dst_ptr    <= '0;
      xfer_done  <= 1'b0;
    end else begin
      xfer_done <= finish;
      case (state)
        S_IDLE: begin
          if (ptr_load) begin
            src_ptr <= ptr_src_in;
            dst_ptr <= ptr_dst_in;
          end else if (start) begin
            state      <= S_RD0;
            l_word     <= cfg_word;
            l_split    <= cfg_word && (src_ptr[0] || dst_ptr[0]);
            l_src_io   <= cfg_src_io;
            l_dst_io   <= cfg_dst_io;
            l_src_mode <= cfg_src_mode;
            l_dst_mode <= cfg_dst_mode;
          end
        end
        S_RD0: if (bus_ready) begin
          if (bus_word) hold <= 16'(bus_rdata);
          else          hold[7:0] <= rd_byte;
          state <= l_split ? S_RD1 : S_WR0;
        end
        S_RD1: if (bus_ready) begin
          hold[15:8] <= rd_byte;
          state      <= S_WR0;
        end
        S_WR0: if (bus_ready) state <= l_split ? S_WR1 : S_IDLE;
        S_WR1: if (bus_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (finish) begin
        src_ptr <= step_ptr(src_ptr, l_src_mode, l_word);
        dst_ptr <= step_ptr(dst_ptr, l_dst_mode, l_word);
      end
    end
  end

  a_r10_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_io)
      && $stable(bus_word) && $stable(bus_write) && $stable(bus_wdata));

  a_r8_err_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && cfg_err |=> !bus_valid);

  a_r9_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && !cfg_arm |=> !bus_valid);

  a_r7_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_word |-> !bus_addr[0]);

  a_r5_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> !bus_write);

  a_r3_ptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !finish && !((state == S_IDLE) && ptr_load) |=> $stable(src_ptr) && $stable(dst_ptr));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
endmodule

// File: tb/test_dma_xfer_chan.sv
module test_dma_xfer_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_arm = 0, cfg_word = 0, cfg_src_io = 0, cfg_dst_io = 0;
  logic [1:0] cfg_src_mode = 0, cfg_dst_mode = 0;
  logic ptr_load = 0;
  logic [19:0] ptr_src_in = 0, ptr_dst_in = 0;
  logic ext_req = 0, int_req = 0, sw_req = 0;
  logic bus_valid, bus_ready, bus_write, bus_io, bus_word;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [19:0] src_ptr, dst_ptr;
  logic busy, cfg_err, xfer_done;

  dma_xfer_chan i_dma_xfer_chan (
    .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_word(cfg_word),
    .cfg_src_io(cfg_src_io), .cfg_dst_io(cfg_dst_io),
    .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
    .ptr_load(ptr_load), .ptr_src_in(ptr_src_in), .ptr_dst_in(ptr_dst_in),
    .ext_req(ext_req), .int_req(int_req), .sw_req(sw_req),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_io(bus_io), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .busy(busy),
    .cfg_err(cfg_err), .xfer_done(xfer_done));

  logic n8_word = 0, n8_sw = 0;
  logic n8_valid, n8_write, n8_io, n8_wordo, n8_busy, n8_err, n8_done;
  logic [19:0] n8_addr, n8_sp, n8_dp;
  logic [7:0] n8_wdata;
  logic n8_seen = 0;

  dma_xfer_chan #(.ADDR_W(20), .BUS_W(8)) i_dma_xfer_chan_n8 (
    .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_word(n8_word),
    .cfg_src_io(1'b0), .cfg_dst_io(1'b0), .cfg_src_mode(2'b00), .cfg_dst_mode(2'b00),
    .ptr_load(1'b0), .ptr_src_in(20'h0), .ptr_dst_in(20'h0),
    .ext_req(1'b0), .int_req(1'b0), .sw_req(n8_sw),
    .bus_valid(n8_valid), .bus_ready(1'b1), .bus_write(n8_write),
    .bus_io(n8_io), .bus_word(n8_wordo), .bus_addr(n8_addr),
    .bus_wdata(n8_wdata), .bus_rdata(8'h00),
    .src_ptr(n8_sp), .dst_ptr(n8_dp), .busy(n8_busy),
    .cfg_err(n8_err), .xfer_done(n8_done));

  int wait_n = 0;
  int wcnt = 0;
  assign bus_ready = bus_valid && (wcnt >= wait_n);

  function automatic logic [7:0] byte_at(input logic [19:0] a, input logic io);
    return a[7:0] ^ (io ? 8'h3C : 8'h5A);
  endfunction

  always_comb begin
    if (bus_word) bus_rdata = {byte_at(bus_addr + 20'd1, bus_io), byte_at(bus_addr, bus_io)};
    else if (bus_addr[0]) bus_rdata = {byte_at(bus_addr, bus_io), 8'hEE};
    else bus_rdata = {8'hEE, byte_at(bus_addr, bus_io)};
  end

  logic        lg_wr [256];
  logic        lg_io [256];
  logic        lg_wd [256];
  logic [19:0] lg_ad [256];
  logic [15:0] lg_dt [256];
  int log_n = 0;

  always @(posedge clk) begin
    if (bus_valid && !bus_ready) wcnt <= wcnt + 1; else wcnt <= 0;
    if (bus_valid && bus_ready && log_n < 256) begin
      lg_wr[log_n] = bus_write;
      lg_io[log_n] = bus_io;
      lg_wd[log_n] = bus_word;
      lg_ad[log_n] = bus_addr;
      lg_dt[log_n] = bus_wdata;
      log_n = log_n + 1;
    end
    if (n8_valid) n8_seen <= 1'b1;
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_cyc(input string rq, input int i, input logic wr, input logic io,
                         input logic wd, input logic [19:0] ad, input logic [15:0] dt);
    chk({rq, " dir"},  32'(lg_wr[i]), 32'(wr));
    chk({rq, " space"}, 32'(lg_io[i]), 32'(io));
    chk({rq, " size"}, 32'(lg_wd[i]), 32'(wd));
    chk({rq, " addr"}, 32'(lg_ad[i]), 32'(ad));
    if (wr) chk({rq, " data"}, 32'(lg_dt[i]), 32'(dt));
  endtask

  task automatic load_ptrs(input logic [19:0] s, input logic [19:0] d);
    @(negedge clk); ptr_load = 1; ptr_src_in = s; ptr_dst_in = d;
    @(negedge clk); ptr_load = 0;
  endtask

  task automatic setup(input logic w, input logic sio, input logic dio,
                       input logic [1:0] sm, input logic [1:0] dm);
    @(negedge clk);
    cfg_arm = 1; cfg_word = w; cfg_src_io = sio; cfg_dst_io = dio;
    cfg_src_mode = sm; cfg_dst_mode = dm;
  endtask

  task automatic wait_done(input string rq);
    int n = 0;
    while (!xfer_done && n < 300) begin @(negedge clk); n++; end
    chk({rq, " completion"}, 32'(xfer_done), 32'd1);
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_req = 1;
    @(negedge clk); sw_req = 0;
  endtask

  task automatic t_reset();
    chk("R12 valid", 32'(bus_valid), 0);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 done", 32'(xfer_done), 0);
    chk("R12 src", 32'(src_ptr), 0);
    chk("R12 dst", 32'(dst_ptr), 0);
  endtask

  task automatic t_mem_to_io_byte();
    int b;
    load_ptrs(20'h00010, 20'h12345);
    setup(0, 0, 1, 2'b01, 2'b00);
    b = log_n;
    pulse_sw();
    wait_done("R11");
    chk("R11 ptr with done src", 32'(src_ptr), 32'h00011);
    chk("R3 hold dst", 32'(dst_ptr), 32'h12345);
    @(negedge clk);
    chk("R11 single pulse", 32'(xfer_done), 0);
    chk("R5 cycle count", 32'(log_n - b), 2);
    chk_cyc("R1 R5 fetch mem", b, 0, 0, 0, 20'h00010, 16'h0);
    chk_cyc("R1 R5 deposit io", b + 1, 1, 1, 0, 20'h12345, 16'h4A4A);
  endtask

  task automatic t_io_to_mem_word();
    int b;
    load_ptrs(20'h1F000, 20'h00200);
    setup(1, 1, 0, 2'b10, 2'b01);
    b = log_n;
    pulse_sw();
    wait_done("R7");
    chk("R7 cycle count", 32'(log_n - b), 2);
    chk_cyc("R2 R7 fetch io high", b, 0, 1, 1, 20'h1F000, 16'h0);
    chk_cyc("R7 deposit word", b + 1, 1, 0, 1, 20'h00200, 16'h3D3C);
    chk("R4 R3 dec by 2", 32'(src_ptr), 32'h1EFFE);
    chk("R4 R3 inc by 2", 32'(dst_ptr), 32'h00202);
  endtask

  task automatic t_odd_word();
    int b;
    load_ptrs(20'h00101, 20'h00300);
    setup(1, 0, 0, 2'b01, 2'b01);
    b = log_n;
    pulse_sw();
    wait_done("R6");
    chk("R6 cycle count", 32'(log_n - b), 4);
    chk_cyc("R6 fetch lo", b, 0, 0, 0, 20'h00101, 16'h0);
    chk_cyc("R6 fetch hi", b + 1, 0, 0, 0, 20'h00102, 16'h0);
    chk_cyc("R6 R5 deposit lo", b + 2, 1, 0, 0, 20'h00300, 16'h5B5B);
    chk_cyc("R6 R5 deposit hi", b + 3, 1, 0, 0, 20'h00301, 16'h5858);
    chk("R6 R4 src", 32'(src_ptr), 32'h00103);
    chk("R6 R4 dst", 32'(dst_ptr), 32'h00302);
  endtask

  task automatic t_io_io_wrap();
    int b;
    load_ptrs(20'hFFFFF, 20'h00000);
    setup(0, 1, 1, 2'b01, 2'b10);
    b = log_n;
    pulse_sw();
    wait_done("R3");
    chk_cyc("R1 R2 fetch io", b, 0, 1, 0, 20'hFFFFF, 16'h0);
    chk_cyc("R1 deposit io", b + 1, 1, 1, 0, 20'h00000, 16'hC3C3);
    chk("R3 wrap up", 32'(src_ptr), 32'h00000);
    chk("R3 wrap down", 32'(dst_ptr), 32'hFFFFF);
  endtask

  task automatic t_unarmed();
    int b;
    load_ptrs(20'h00500, 20'h00600);
    setup(0, 0, 0, 2'b01, 2'b01);
    @(negedge clk); cfg_arm = 0; ext_req = 1; int_req = 1; sw_req = 1;
    b = log_n;
    repeat (8) @(negedge clk);
    chk("R9 no cycles unarmed", 32'(log_n - b), 0);
    chk("R9 not busy", 32'(busy), 0);
    chk("R9 src unchanged", 32'(src_ptr), 32'h00500);
    ext_req = 0; int_req = 0; sw_req = 0;
  endtask

  task automatic t_sources();
    int b;
    load_ptrs(20'h00020, 20'h00030);
    setup(0, 0, 0, 2'b00, 2'b00);
    b = log_n;
    @(negedge clk); ext_req = 1;
    @(negedge clk); ext_req = 0;
    wait_done("R9 ext");
    chk("R9 ext cycles", 32'(log_n - b), 2);
    chk_cyc("R9 ext data", b + 1, 1, 0, 0, 20'h00030, 16'h7A7A);
    @(negedge clk);
    b = log_n;
    @(negedge clk); int_req = 1;
    @(negedge clk); int_req = 0;
    wait_done("R9 int");
    chk("R9 int cycles", 32'(log_n - b), 2);
  endtask

  task automatic t_wait_and_load();
    int b;
    wait_n = 3;
    load_ptrs(20'h00040, 20'h00080);
    setup(0, 0, 0, 2'b01, 2'b01);
    b = log_n;
    @(negedge clk); sw_req = 1;
    @(negedge clk); sw_req = 0; ptr_load = 1; ptr_src_in = 20'hAAAAA; ptr_dst_in = 20'h55555;
    @(negedge clk); ptr_load = 0;
    wait_done("R10");
    chk("R10 cycles with waits", 32'(log_n - b), 2);
    chk_cyc("R10 deposit", b + 1, 1, 0, 0, 20'h00080, 16'h1A1A);
    chk("R13 load ignored src", 32'(src_ptr), 32'h00041);
    chk("R13 load ignored dst", 32'(dst_ptr), 32'h00081);
    wait_n = 0;
  endtask

  task automatic t_narrow_bus();
    @(negedge clk); n8_word = 1; cfg_arm = 1; n8_sw = 1;
    repeat (8) @(negedge clk);
    chk("R8 err flag", 32'(n8_err), 1);
    chk("R8 no cycles", 32'(n8_seen), 0);
    n8_word = 0;
    repeat (4) @(negedge clk);
    chk("R8 err clears", 32'(n8_err), 0);
    chk("R8 byte runs", 32'(n8_seen), 1);
    n8_sw = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_mem_to_io_byte();
    t_io_to_mem_word();
    t_odd_word();
    t_io_io_wrap();
    t_unarmed();
    t_sources();
    t_wait_and_load();
    t_narrow_bus();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule